// File: doc/BRIEF.md
# Prioritized Exception and Interrupt Acceptance Unit

This unit decides, once per retired instruction, whether the core must leave its program flow for a handler. It keeps a 32-bit vector of pending requests, filters it through the mask field of the processor status word, and picks the request with the highest index. Requests 16 to 31 are synchronous exceptions. They ignore the global interrupt enable and are removed from the pending vector when accepted. Requests 0 to 15 are level-sensitive interrupts. An interrupt stays pending until its source drops it through the clear strobe.

On acceptance the unit pushes the user-mode flag and the interrupt-enable flag one slot deeper into a three-entry stack held inside the status word. It clears the current slot of both and writes the accepted number into the status word's priority field. It issues a one-cycle redirect with the handler address, and a link strobe carrying the PC, which the core writes into its return-address register (r30). A return-from-exception request pops the stack and redirects to the supplied return address. If the return is attempted in user mode, the unit raises the privileged-instruction exception instead.

Nothing in this unit carries a data stream. Every pin is a plain control or status signal. `redirect_o` and `link_we_o` are single-cycle strobes with no back-pressure: the core consumes them in the cycle they appear.

Top module: `excp_unit`

## Requirements
- R1: After reset, `sr_o`, `pending_o`, `redirect_o` and `link_we_o` are all zero.
- R2: A set strobe ORs bit `req_set_idx_i` into the pending vector and a clear strobe removes bit `req_clr_idx_i`, one cycle later. When both strobes name the same bit in one cycle, the clear wins.
- R3: Pending bits 16..31 are always candidates. A pending bit k below 16 is a candidate only while status bit k (the mask field, bits 15:0) is 1.
- R4: Among the candidates, the one with the highest index is chosen.
- R5: On `step_i`, a chosen request at index 16 or above is accepted whatever the enable bit holds. A chosen request below 16 is accepted only while the enable bit (status bit 23) is 1. Without acceptance there is no redirect and no change to the status word.
- R6: Acceptance clears the accepted pending bit only when its index is 16 or more. Interrupt bits remain set.
- R7: On acceptance, old-enable (bit 21) takes previous-enable (bit 22), previous-enable takes enable (bit 23), and enable clears. Old-user (bit 24) takes previous-user (bit 25), previous-user takes user (bit 26), and user clears. The accepted index goes into bits 20:16. Bit 27 and the mask field are kept.
- R8: On acceptance, `link_we_o` pulses together with `redirect_o`, and `link_o` holds the PC presented in the decision cycle.
- R9: The handler base is 0xE0000000 (0xC0000000 ORed with the boot-ROM base 0x20000000) while status bit 27 is 0, and 0xC0000000 while it is 1.
- R10: The handler address is base+8 when the accepted index is 21 (translation miss) and `fault_hi_i` is 0. It is base+4 in every other case.
- R11: A return request in kernel mode (bit 26 = 0) sets enable from previous-enable, previous-enable from old-enable, user from previous-user, and previous-user from old-user. Old-enable and old-user keep their values. The unit redirects to `ret_addr_i` without a link strobe.
- R12: A return request in user mode leaves the status word unchanged, produces no redirect, and sets pending bit 18 (privileged instruction).
- R13: `sr_we_i` loads `sr_wdata_i` into the status word. A return request takes precedence over a load, and a load takes precedence over acceptance: a load in a `step_i` cycle suppresses acceptance for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_set_i | input | 1 | Raise the pending bit given by req_set_idx_i |
| req_set_idx_i | input | 5 | Index of the request to raise |
| req_clr_i | input | 1 | Drop the pending bit given by req_clr_idx_i |
| req_clr_idx_i | input | 5 | Index of the request to drop |
| step_i | input | 1 | An instruction retired; evaluate acceptance |
| pc_i | input | 32 | PC to be saved as the link value |
| fault_hi_i | input | 1 | Top bit of the faulting address |
| rfx_i | input | 1 | Return-from-exception request |
| ret_addr_i | input | 32 | Return address (current r30 contents) |
| sr_we_i | input | 1 | Load the status word |
| sr_wdata_i | input | 32 | Status word value to load |
| sr_o | output | 32 | Status word |
| pending_o | output | 32 | Pending request vector |
| redirect_o | output | 1 | One-cycle strobe: fetch from target_o |
| target_o | output | 32 | Handler or return address |
| link_we_o | output | 1 | One-cycle strobe: write link_o to r30 |
| link_o | output | 32 | Saved PC |

## Verification
The hardest state to reach from the ports is the user-mode return. The status stack must first be filled by a software load, and a kernel-mode return must then pop user mode into the current slot. The second return is the one that must fail and raise request 18, which a later retire then accepts through a full stack push. The translation-miss offset needs request 21 pending, with the faulting-address top bit both clear and set. The load-versus-accept precedence needs a pending exception present in the very cycle the status word is rewritten.

// File: rtl/excp_pkg.sv
package excp_pkg;

  // What the unit does to its state in a given cycle.
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_ACCEPT,
    ACT_RETURN,
    ACT_RET_PRIV,
    ACT_LOAD
  } act_e;

  // One-hot word of width n with bit idx set when en is high.
  function automatic logic [63:0] onehot64(input logic en, input int unsigned idx);
    logic [63:0] w;
    w = '0;
    if (en) w[idx] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/excp_pending.sv
module excp_pending #(
  parameter int NREQ = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREQ-1:0] set_mask_i,
  input  logic [NREQ-1:0] clr_mask_i,
  output logic [NREQ-1:0] pend_o
);

  logic [NREQ-1:0] pend_q;

  // Clear dominates set in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q | set_mask_i) & ~clr_mask_i;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/excp_select.sv
module excp_select #(
  parameter int NREQ = 32,
  parameter int NINT = 16,
  localparam int IDXW = $clog2(NREQ)
) (
  input  logic [NREQ-1:0] pend_i,
  input  logic [NINT-1:0] mask_i,
  output logic            vld_o,
  output logic [IDXW-1:0] idx_o
);

  logic [NREQ-1:0] pass;
  logic [NREQ-1:0] cand;

  // Interrupt lines obey the mask field; exception lines always pass.
  for (genvar g = 0; g < NREQ; g++) begin : g_pass
    if (g < NINT) begin : g_int
      assign pass[g] = mask_i[g];
    end else begin : g_exc
      assign pass[g] = 1'b1;
    end
  end

  assign cand  = pend_i & pass;
  assign vld_o = |cand;

  // Ascending scan: the last hit is the highest index.
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (cand[i]) idx_o = IDXW'(i);
    end
  end

endmodule

// File: rtl/excp_status.sv
module excp_status
  import excp_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int IDXW     = 5,
  parameter int V_BIT    = 27,
  parameter int UM_BIT   = 26,
  parameter int PUM_BIT  = 25,
  parameter int OUM_BIT  = 24,
  parameter int IE_BIT   = 23,
  parameter int PIE_BIT  = 22,
  parameter int OIE_BIT  = 21,
  parameter int PRIO_LSB = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  act_e            act_i,
  input  logic [IDXW-1:0] win_idx_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] sr_o
);

  logic [XLEN-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    unique case (act_i)
      ACT_ACCEPT: begin
        sr_d[OIE_BIT] = sr_q[PIE_BIT];
        sr_d[PIE_BIT] = sr_q[IE_BIT];
        sr_d[IE_BIT]  = 1'b0;
        sr_d[OUM_BIT] = sr_q[PUM_BIT];
        sr_d[PUM_BIT] = sr_q[UM_BIT];
        sr_d[UM_BIT]  = 1'b0;
        sr_d[PRIO_LSB +: IDXW] = win_idx_i;
      end
      ACT_RETURN: begin
        sr_d[IE_BIT]  = sr_q[PIE_BIT];
        sr_d[PIE_BIT] = sr_q[OIE_BIT];
        sr_d[UM_BIT]  = sr_q[PUM_BIT];
        sr_d[PUM_BIT] = sr_q[OUM_BIT];
      end
      ACT_LOAD: sr_d = wdata_i;
      default:  sr_d = sr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign sr_o = sr_q;

endmodule

// File: rtl/excp_vector.sv
module excp_vector #(
  parameter int              XLEN          = 32,
  parameter int              IDXW          = 5,
  parameter int              TLB_MISS_PRIO = 21,
  parameter logic [XLEN-1:0] VEC_BASE      = 32'hC000_0000,
  parameter logic [XLEN-1:0] ROM_BASE      = 32'h2000_0000,
  parameter logic [XLEN-1:0] OFF_USER_TLB  = 32'h0000_0008,
  parameter logic [XLEN-1:0] OFF_GENERAL   = 32'h0000_0004
) (
  input  logic            ram_sel_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic            fault_hi_i,
  output logic [XLEN-1:0] vec_o
);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] off;
  logic            user_miss;

  assign base      = ram_sel_i ? VEC_BASE : (VEC_BASE | ROM_BASE);
  assign user_miss = (idx_i == IDXW'(TLB_MISS_PRIO)) && !fault_hi_i;
  assign off       = user_miss ? OFF_USER_TLB : OFF_GENERAL;
  assign vec_o     = base | off;

endmodule

// File: rtl/excp_unit.sv
module excp_unit
  import excp_pkg::*;
#(
  parameter int              XLEN          = 32,
  parameter int              NREQ          = 32,
  parameter int              NINT          = 16,
  parameter int              TLB_MISS_PRIO = 21,
  parameter int              PRIV_PRIO     = 18,
  parameter logic [XLEN-1:0] VEC_BASE      = 32'hC000_0000,
  parameter logic [XLEN-1:0] ROM_BASE      = 32'h2000_0000,
  parameter int              V_BIT         = 27,
  parameter int              UM_BIT        = 26,
  parameter int              PUM_BIT       = 25,
  parameter int              OUM_BIT       = 24,
  parameter int              IE_BIT        = 23,
  parameter int              PIE_BIT       = 22,
  parameter int              OIE_BIT       = 21,
  parameter int              PRIO_LSB      = 16,
  localparam int             IDXW          = $clog2(NREQ)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_set_i,
  input  logic [IDXW-1:0] req_set_idx_i,
  input  logic            req_clr_i,
  input  logic [IDXW-1:0] req_clr_idx_i,
  input  logic            step_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            fault_hi_i,
  input  logic            rfx_i,
  input  logic [XLEN-1:0] ret_addr_i,
  input  logic            sr_we_i,
  input  logic [XLEN-1:0] sr_wdata_i,
  output logic [XLEN-1:0] sr_o,
  output logic [NREQ-1:0] pending_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] target_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_o
);

  logic [XLEN-1:0] sr;
  logic [NREQ-1:0] pend;
  logic            win_vld;
  logic [IDXW-1:0] win_idx;
  logic            win_is_exc;
  logic [XLEN-1:0] vec;
  act_e            act;
  logic [NREQ-1:0] set_mask, clr_mask;

  assign win_is_exc = (win_idx >= IDXW'(NINT));

  // Return beats load, load beats acceptance.
  always_comb begin
    act = ACT_IDLE;
    if (rfx_i)        act = sr[UM_BIT] ? ACT_RET_PRIV : ACT_RETURN;
    else if (sr_we_i) act = ACT_LOAD;
    else if (step_i && win_vld && (win_is_exc || sr[IE_BIT])) act = ACT_ACCEPT;
  end

  assign set_mask = NREQ'(onehot64(req_set_i, 32'(req_set_idx_i)))
                  | NREQ'(onehot64(act == ACT_RET_PRIV, PRIV_PRIO));
  assign clr_mask = NREQ'(onehot64(req_clr_i, 32'(req_clr_idx_i)))
                  | NREQ'(onehot64((act == ACT_ACCEPT) && win_is_exc, 32'(win_idx)));

  excp_pending #(.NREQ(NREQ)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_mask_i (set_mask),
    .clr_mask_i (clr_mask),
    .pend_o     (pend)
  );

  excp_select #(.NREQ(NREQ), .NINT(NINT)) u_sel (
    .pend_i (pend),
    .mask_i (sr[NINT-1:0]),
    .vld_o  (win_vld),
    .idx_o  (win_idx)
  );

  excp_status #(
    .XLEN(XLEN), .IDXW(IDXW), .V_BIT(V_BIT), .UM_BIT(UM_BIT), .PUM_BIT(PUM_BIT),
    .OUM_BIT(OUM_BIT), .IE_BIT(IE_BIT), .PIE_BIT(PIE_BIT), .OIE_BIT(OIE_BIT),
    .PRIO_LSB(PRIO_LSB)
  ) u_sr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act),
    .win_idx_i (win_idx),
    .wdata_i   (sr_wdata_i),
    .sr_o      (sr)
  );

  excp_vector #(
    .XLEN(XLEN), .IDXW(IDXW), .TLB_MISS_PRIO(TLB_MISS_PRIO),
    .VEC_BASE(VEC_BASE), .ROM_BASE(ROM_BASE)
  ) u_vec (
    .ram_sel_i  (sr[V_BIT]),
    .idx_i      (win_idx),
    .fault_hi_i (fault_hi_i),
    .vec_o      (vec)
  );

  logic            redir_q, link_we_q;
  logic [XLEN-1:0] target_q, link_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_q   <= 1'b0;
      link_we_q <= 1'b0;
      target_q  <= '0;
      link_q    <= '0;
    end else begin
      redir_q   <= (act == ACT_ACCEPT) || (act == ACT_RETURN);
      link_we_q <= (act == ACT_ACCEPT);
      target_q  <= (act == ACT_ACCEPT) ? vec : ret_addr_i;
      link_q    <= pc_i;
    end
  end

  assign sr_o       = sr;
  assign pending_o  = pend;
  assign redirect_o = redir_q;
  assign link_we_o  = link_we_q;
  assign target_o   = target_q;
  assign link_o     = link_q;

endmodule

// File: rtl/excp_unit_chk.sv
module excp_unit_chk #(
  parameter int              XLEN          = 32,
  parameter int              NREQ          = 32,
  parameter int              NINT          = 16,
  parameter int              TLB_MISS_PRIO = 21,
  parameter int              PRIV_PRIO     = 18,
  parameter logic [XLEN-1:0] ROM_BASE      = 32'h2000_0000,
  parameter int              V_BIT         = 27,
  parameter int              UM_BIT        = 26,
  parameter int              PUM_BIT       = 25,
  parameter int              IE_BIT        = 23,
  parameter int              PIE_BIT       = 22,
  parameter int              PRIO_LSB      = 16,
  localparam int             IDXW          = $clog2(NREQ)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_set_i,
  input logic [IDXW-1:0] req_set_idx_i,
  input logic            req_clr_i,
  input logic [IDXW-1:0] req_clr_idx_i,
  input logic            rfx_i,
  input logic            fault_hi_i,
  input logic [XLEN-1:0] sr_o,
  input logic [NREQ-1:0] pending_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] target_o,
  input logic            link_we_o
);

  logic [IDXW-1:0] prio;
  assign prio = sr_o[PRIO_LSB +: IDXW];

  // R2
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_clr_i |=> !pending_o[$past(req_clr_idx_i)]);

  // R5
  intr_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_we_o && (prio < IDXW'(NINT))) |-> $past(sr_o[IE_BIT]));

  // R6
  exc_retired_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_we_o && (prio >= IDXW'(NINT)) && !($past(req_set_i) && ($past(req_set_idx_i) == prio)))
      |-> !pending_o[prio]);

  // R7
  current_slot_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (!sr_o[IE_BIT] && !sr_o[UM_BIT]));

  // R7
  stack_pushed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> ((sr_o[PIE_BIT] == $past(sr_o[IE_BIT])) && (sr_o[PUM_BIT] == $past(sr_o[UM_BIT]))));

  // R8
  link_with_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> redirect_o);

  // R9
  vector_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (((target_o & ROM_BASE) != '0) == !$past(sr_o[V_BIT])));

  // R10
  vector_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> ((target_o[3:0] == 4'h8) == ((prio == IDXW'(TLB_MISS_PRIO)) && !$past(fault_hi_i))));

  // R12
  user_return_traps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfx_i && sr_o[UM_BIT] && !(req_clr_i && (req_clr_idx_i == IDXW'(PRIV_PRIO))))
      |=> (!redirect_o && pending_o[PRIV_PRIO]));

endmodule

bind excp_unit excp_unit_chk #(
  .XLEN(XLEN), .NREQ(NREQ), .NINT(NINT), .TLB_MISS_PRIO(TLB_MISS_PRIO),
  .PRIV_PRIO(PRIV_PRIO), .ROM_BASE(ROM_BASE), .V_BIT(V_BIT), .UM_BIT(UM_BIT),
  .PUM_BIT(PUM_BIT), .IE_BIT(IE_BIT), .PIE_BIT(PIE_BIT), .PRIO_LSB(PRIO_LSB)
) u_chk (.*);

// File: tb/test_excp_unit.sv
`timescale 1ns/1ps
module test_excp_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_set = 1'b0, req_clr = 1'b0, step = 1'b0, fault_hi = 1'b0;
  logic        rfx = 1'b0, sr_we = 1'b0;
  logic [4:0]  set_idx = '0, clr_idx = '0;
  logic [31:0] pc = '0, ret_addr = '0, sr_wdata = '0;
  logic [31:0] sr, pending, target, link;
  logic        redirect, link_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  excp_unit i_excp_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .req_set_i(req_set), .req_set_idx_i(set_idx),
    .req_clr_i(req_clr), .req_clr_idx_i(clr_idx),
    .step_i(step), .pc_i(pc), .fault_hi_i(fault_hi),
    .rfx_i(rfx), .ret_addr_i(ret_addr),
    .sr_we_i(sr_we), .sr_wdata_i(sr_wdata),
    .sr_o(sr), .pending_o(pending), .redirect_o(redirect),
    .target_o(target), .link_we_o(link_we), .link_o(link)
  );

  typedef struct packed {
    logic [31:0] pend;
    logic [31:0] sr0;
    logic [31:0] pcv;
    logic        fhi;
    logic        redir;
    logic [31:0] tgt;
    logic [31:0] sr_exp;
    logic [31:0] pend_exp;
  } vec_t;

  // pend, status, pc, fault_hi, redirect, target, status after, pending after
  localparam vec_t TBL [0:8] = '{
    '{32'h0010_0001, 32'h0000_0000, 32'h0000_1000, 1'b0, 1'b1, 32'hE000_0004, 32'h0014_0000, 32'h0000_0001}, // R3 R6 R9
    '{32'h0000_0008, 32'h0000_0008, 32'h0000_1010, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0008, 32'h0000_0008}, // R5
    '{32'h0000_0008, 32'h0CA0_0008, 32'h0000_1020, 1'b0, 1'b1, 32'hC000_0004, 32'h0A43_0008, 32'h0000_0008}, // R6 R7 R9
    '{32'h0000_8004, 32'h0080_0004, 32'h0000_1030, 1'b0, 1'b1, 32'hE000_0004, 32'h0042_0004, 32'h0000_8004}, // R3 R4
    '{32'h0020_0020, 32'h00C0_0020, 32'h0000_1040, 1'b0, 1'b1, 32'hE000_0008, 32'h0075_0020, 32'h0000_0020}, // R10 R7
    '{32'h0020_0000, 32'h0000_0000, 32'h0000_1050, 1'b1, 1'b1, 32'hE000_0004, 32'h0015_0000, 32'h0000_0000}, // R10
    '{32'h8001_0000, 32'h0800_0000, 32'h0000_1060, 1'b0, 1'b1, 32'hC000_0004, 32'h081F_0000, 32'h0001_0000}, // R4 R9
    '{32'h0000_0000, 32'h0080_FFFF, 32'h0000_1070, 1'b0, 1'b0, 32'h0000_0000, 32'h0080_FFFF, 32'h0000_0000}, // R5
    '{32'h0001_0000, 32'h0500_0000, 32'h0000_1080, 1'b0, 1'b1, 32'hE000_0004, 32'h0210_0000, 32'h0000_0000}  // R7
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_sr(input logic [31:0] v);
    sr_we = 1'b1; sr_wdata = v;
    @(negedge clk);
    sr_we = 1'b0;
  endtask

  task automatic raise(input logic [4:0] b);
    req_set = 1'b1; set_idx = b;
    @(negedge clk);
    req_set = 1'b0;
  endtask

  task automatic retire(input logic [31:0] p, input logic fh);
    pc = p; fault_hi = fh; step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic ret_req(input logic [31:0] a);
    ret_addr = a; rfx = 1'b1;
    @(negedge clk);
    rfx = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1", "status", sr, 32'h0);
    chk("R1", "pending", pending, 32'h0);
    chk("R1", "redirect", {31'b0, redirect}, 32'h0);
    chk("R1", "link_we", {31'b0, link_we}, 32'h0);

    for (int i = 0; i < 9; i++) begin
      do_reset();
      load_sr(TBL[i].sr0);
      for (int b = 0; b < 32; b++) if (TBL[i].pend[b]) raise(5'(b));
      retire(TBL[i].pcv, TBL[i].fhi);
      $display("row %0d: R3 R4 R5 R6 R7 R8 R9 R10", i);
      chk("R5", "redirect", {31'b0, redirect}, {31'b0, TBL[i].redir});
      chk("R8", "link_we", {31'b0, link_we}, {31'b0, TBL[i].redir});
      if (TBL[i].redir) begin
        chk("R9 R10", "target", target, TBL[i].tgt);
        chk("R8", "link", link, TBL[i].pcv);
      end
      chk("R7", "status", sr, TBL[i].sr_exp);
      chk("R6", "pending", pending, TBL[i].pend_exp);
    end

    // R2: set, then set and clear of one bit together, then clear
    do_reset();
    raise(5'd9);
    chk("R2", "pending after set", pending, 32'h0000_0200);
    req_set = 1'b1; set_idx = 5'd7; req_clr = 1'b1; clr_idx = 5'd7;
    @(negedge clk);
    req_set = 1'b0; req_clr = 1'b0;
    chk("R2", "clear beats set", pending, 32'h0000_0200);
    req_clr = 1'b1; clr_idx = 5'd9;
    @(negedge clk);
    req_clr = 1'b0;
    chk("R2", "pending after clear", pending, 32'h0);

    // R11: kernel-mode return pops the stack
    do_reset();
    load_sr(32'h0360_0000);
    ret_req(32'h4000_0010);
    chk("R11", "redirect", {31'b0, redirect}, 32'h1);
    chk("R11", "link_we", {31'b0, link_we}, 32'h0);
    chk("R11", "target", target, 32'h4000_0010);
    chk("R11", "status", sr, 32'h07E0_0000);

    // R12: user-mode return raises request 18, which is then accepted
    ret_req(32'h5000_0000);
    chk("R12", "redirect", {31'b0, redirect}, 32'h0);
    chk("R12", "status", sr, 32'h07E0_0000);
    chk("R12", "pending", pending, 32'h0004_0000);
    retire(32'h0000_2000, 1'b0);
    chk("R12", "accept redirect", {31'b0, redirect}, 32'h1);
    chk("R12", "accept target", target, 32'hE000_0004);
    chk("R8", "link", link, 32'h0000_2000);
    chk("R7", "status after push", sr, 32'h0372_0000);
    chk("R6", "pending after accept", pending, 32'h0);

    // R13: a load in a retire cycle wins over acceptance
    do_reset();
    raise(5'd20);
    sr_we = 1'b1; sr_wdata = 32'h0000_0005; step = 1'b1; pc = 32'h3000;
    @(negedge clk);
    sr_we = 1'b0; step = 1'b0;
    chk("R13", "redirect", {31'b0, redirect}, 32'h0);
    chk("R13", "status", sr, 32'h0000_0005);
    chk("R13", "pending", pending, 32'h0010_0000);
    retire(32'h0000_3004, 1'b0);
    chk("R13", "later accept status", sr, 32'h0014_0005);
    chk("R13", "later accept target", target, 32'hE000_0004);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule